// File: doc/BRIEF.md
# Two-Level Outstanding Line Tracker

This block keeps a small, fully associative table of cache-line requests that are still in flight for an inner and an outer cache level. Each slot holds a line tag, a two-bit mask of the levels for which the line is still pending, and one prefetch flag per level. A single request port performs a lookup on every valid cycle. When allocation is asked for, the same cycle either places the line in a free slot or widens an existing slot to cover the other level as well.

Per-level completion strobes narrow or free slots. Two counters report, every cycle, how many slots are pending at each level. A demand lookup that lands on a line brought in by a prefetch clears that level's prefetch flag and raises a one-cycle late-prefetch pulse. This lets the surrounding prefetch logic measure timeliness.

Level encoding: level 0 is the inner cache and level 1 is the outer cache. Result encoding on `res_o`: 0 = absent, 1 = demand-owned, 2 = prefetch-owned, 3 = pending only at the other level.

Top module: `miss_track_table`

## Requirements
- R1: After reset both counts are 0, `late_o` is 0, and every lookup returns 0 (absent).
- R2: Address bits below the 64-byte line boundary (bits [5:0]) are ignored on lookup, allocation and completion.
- R3: `res_o` is valid in the same cycle as `req_valid_i`. It is 0 when no slot holds the line. It is 1 or 2 when the line is pending at the requested level, with the prefetch flag of that level clear or set respectively. It is 3 when the line is pending only at the other level.
- R4: An allocating request for an absent line takes a free slot and raises `alloc_done_o`. The line becomes pending at the requested level only, with that level's prefetch flag set exactly when `req_demand_i` is 0.
- R5: When every slot is in use, an allocating request for an absent line leaves `alloc_done_o` low and changes no count.
- R6: An allocating request that finds the line pending only at the other level raises `alloc_done_o`. The slot becomes pending at both levels and counts toward both. A prefetch merge sets the prefetch flag of the newly added level. The slot then answers lookups from either level.
- R7: A demand lookup (`req_demand_i`=1) that hits at the requested level returns the current prefetch flag and then clears it. A non-demand lookup leaves the flag unchanged.
- R8: When a demand lookup returns 2, `late_o[level]` is high in the following cycle only.
- R9: A completion for level L clears L from the matching slot. A both-level slot reverts to the other level, and a slot with no level left is freed. A completion for a level at which the line is not pending has no effect.
- R10: `cnt_inner_o` and `cnt_outer_o` give the number of slots pending at level 0 and level 1, updated in the cycle after each change.
- R11: A request sees the table as it was before any completion in the same cycle. A slot freed in that cycle is not available to that cycle's allocation, and a line completed in that cycle is still reported present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_lvl_i | input | 1 | Requesting level (0 inner, 1 outer) |
| req_demand_i | input | 1 | 1 = demand request, 0 = prefetch |
| req_alloc_i | input | 1 | Allocate or merge if the line is not pending at this level |
| req_addr_i | input | ADDR_W | Request byte address |
| res_o | output | 2 | Lookup result code |
| alloc_done_o | output | 1 | Allocation or merge performed this cycle |
| cpl_valid_i | input | 2 | Per-level completion strobe |
| cpl_addr0_i | input | ADDR_W | Completed address, level 0 |
| cpl_addr1_i | input | ADDR_W | Completed address, level 1 |
| late_o | output | 2 | Per-level late-prefetch pulse |
| cnt_inner_o | output | CNT_W | Slots pending at level 0 |
| cnt_outer_o | output | CNT_W | Slots pending at level 1 |

## Verification
The overlap that matters is a request and a completion landing in the same cycle. The bench provokes it in two ways. First, it fills a four-slot table and then asks for a fresh allocation while one slot completes. Second, it sends a demand lookup on a prefetched line while that same line completes. In both cases the result must reflect the table before the edge: the allocation is refused, and the lookup still reports prefetch-owned and pulses `late_o`. The counts one cycle later must show only the completion's effect.

// File: rtl/mtt_pkg.sv
package mtt_pkg;
  typedef enum logic [1:0] {
    LK_ABSENT = 2'd0,
    LK_DEMAND = 2'd1,
    LK_PREF   = 2'd2,
    LK_OTHER  = 2'd3
  } lk_res_e;

  localparam int unsigned NUM_LVL = 2;
endpackage

// File: rtl/mtt_entry.sv
module mtt_entry
  import mtt_pkg::*;
#(
  parameter int TAG_W = 26
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            req_valid_i,
  input  logic                            req_lvl_i,
  input  logic                            req_demand_i,
  input  logic                            req_alloc_i,
  input  logic [TAG_W-1:0]                req_tag_i,
  input  logic                            ins_i,
  input  logic [NUM_LVL-1:0]              cpl_valid_i,
  input  logic [NUM_LVL-1:0][TAG_W-1:0]   cpl_tag_i,
  output logic                            hit_o,
  output logic [NUM_LVL-1:0]              pend_o,
  output logic [NUM_LVL-1:0]              pf_o
);
  logic [TAG_W-1:0]   tag_q, tag_d;
  logic [NUM_LVL-1:0] pend_q, pend_d, pf_q, pf_d, cpl_hit;

  assign hit_o  = (|pend_q) && (tag_q == req_tag_i);
  assign pend_o = pend_q;
  assign pf_o   = pf_q;

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_cpl
    assign cpl_hit[l] = cpl_valid_i[l] && pend_q[l] && (tag_q == cpl_tag_i[l]);
  end

  always_comb begin
    tag_d  = tag_q;
    pend_d = pend_q;
    pf_d   = pf_q;
    if (ins_i) begin
      tag_d             = req_tag_i;
      pend_d            = '0;
      pend_d[req_lvl_i] = 1'b1;
      pf_d              = '0;
      pf_d[req_lvl_i]   = !req_demand_i;
    end else if (req_valid_i && hit_o) begin
      if (pend_q[req_lvl_i]) begin
        if (req_demand_i) pf_d[req_lvl_i] = 1'b0;
      end else if (req_alloc_i) begin
        pend_d[req_lvl_i] = 1'b1;
        if (!req_demand_i) pf_d[req_lvl_i] = 1'b1;
      end
    end
    // completion applied last: it wins over the request on the same level
    for (int l = 0; l < NUM_LVL; l++) begin
      if (cpl_hit[l]) begin
        pend_d[l] = 1'b0;
        pf_d[l]   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q  <= '0;
      pend_q <= '0;
      pf_q   <= '0;
    end else begin
      tag_q  <= tag_d;
      pend_q <= pend_d;
      pf_q   <= pf_d;
    end
  end
endmodule

// File: rtl/mtt_first_free.sv
module mtt_first_free #(
  parameter int N = 128
) (
  input  logic [N-1:0] free_i,
  output logic [N-1:0] sel_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    sel_o = '0;
    for (int i = 0; i < N; i++) begin
      if (free_i[i] && !found) begin
        sel_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mtt_popcnt.sv
module mtt_popcnt #(
  parameter int N = 128,
  parameter int W = $clog2(N + 1)
) (
  input  logic [N-1:0] bits_i,
  output logic [W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < N; i++) cnt_o = cnt_o + W'(bits_i[i]);
  end
endmodule

// File: rtl/miss_track_table.sv
module miss_track_table
  import mtt_pkg::*;
#(
  parameter int DEPTH     = 128,
  parameter int ADDR_W    = 32,
  parameter int LINE_BITS = 6,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_lvl_i,
  input  logic              req_demand_i,
  input  logic              req_alloc_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic [1:0]        res_o,
  output logic              alloc_done_o,
  input  logic [1:0]        cpl_valid_i,
  input  logic [ADDR_W-1:0] cpl_addr0_i,
  input  logic [ADDR_W-1:0] cpl_addr1_i,
  output logic [1:0]        late_o,
  output logic [CNT_W-1:0]  cnt_inner_o,
  output logic [CNT_W-1:0]  cnt_outer_o
);
  localparam int TAG_W = ADDR_W - LINE_BITS;

  logic [TAG_W-1:0]                  req_tag;
  logic [NUM_LVL-1:0][TAG_W-1:0]     cpl_tag;
  logic [DEPTH-1:0]                  hit, valid, ins_sel, pick;
  logic [NUM_LVL-1:0][DEPTH-1:0]     pend_by_lvl;
  logic [NUM_LVL-1:0]                pend_e [DEPTH];
  logic [NUM_LVL-1:0]                pf_e   [DEPTH];
  logic [NUM_LVL-1:0]                hit_pend, hit_pf, late_q, late_d;
  logic                              any_hit, any_free, ins_fire;
  lk_res_e                           res;
  logic                              unused_low;

  assign req_tag    = req_addr_i[ADDR_W-1:LINE_BITS];
  assign cpl_tag[0] = cpl_addr0_i[ADDR_W-1:LINE_BITS];
  assign cpl_tag[1] = cpl_addr1_i[ADDR_W-1:LINE_BITS];
  assign unused_low = ^{req_addr_i[LINE_BITS-1:0], cpl_addr0_i[LINE_BITS-1:0],
                        cpl_addr1_i[LINE_BITS-1:0]};

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    mtt_entry #(.TAG_W(TAG_W)) i_ent (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .req_valid_i (req_valid_i),
      .req_lvl_i   (req_lvl_i),
      .req_demand_i(req_demand_i),
      .req_alloc_i (req_alloc_i),
      .req_tag_i   (req_tag),
      .ins_i       (ins_sel[i]),
      .cpl_valid_i (cpl_valid_i),
      .cpl_tag_i   (cpl_tag),
      .hit_o       (hit[i]),
      .pend_o      (pend_e[i]),
      .pf_o        (pf_e[i])
    );
    assign valid[i]          = |pend_e[i];
    assign pend_by_lvl[0][i] = pend_e[i][0];
    assign pend_by_lvl[1][i] = pend_e[i][1];
  end

  always_comb begin
    hit_pend = '0;
    hit_pf   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      hit_pend |= pend_e[i] & {NUM_LVL{hit[i]}};
      hit_pf   |= pf_e[i]   & {NUM_LVL{hit[i]}};
    end
  end

  assign any_hit  = |hit;
  assign any_free = ~&valid;

  mtt_first_free #(.N(DEPTH)) i_pick (
    .free_i(~valid),
    .sel_o (pick)
  );

  assign ins_fire = req_valid_i && req_alloc_i && !any_hit && any_free;
  assign ins_sel  = pick & {DEPTH{ins_fire}};

  always_comb begin
    if (!req_valid_i || !any_hit)  res = LK_ABSENT;
    else if (hit_pend[req_lvl_i])  res = hit_pf[req_lvl_i] ? LK_PREF : LK_DEMAND;
    else                           res = LK_OTHER;
  end

  assign res_o        = res;
  assign alloc_done_o = req_valid_i && req_alloc_i &&
                        (any_hit ? !hit_pend[req_lvl_i] : any_free);

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_late
    assign late_d[l] = req_valid_i && req_demand_i && (req_lvl_i == l[0]) && (res == LK_PREF);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) late_q <= '0;
    else         late_q <= late_d;
  end
  assign late_o = late_q;

  mtt_popcnt #(.N(DEPTH), .W(CNT_W)) i_cnt_inner (
    .bits_i(pend_by_lvl[0]),
    .cnt_o (cnt_inner_o)
  );
  mtt_popcnt #(.N(DEPTH), .W(CNT_W)) i_cnt_outer (
    .bits_i(pend_by_lvl[1]),
    .cnt_o (cnt_outer_o)
  );
endmodule

// File: rtl/miss_track_table_chk.sv
module miss_track_table_chk #(
  parameter int DEPTH = 128,
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_lvl_i,
  input logic             req_demand_i,
  input logic [1:0]       res_o,
  input logic             alloc_done_o,
  input logic [1:0]       cpl_valid_i,
  input logic [1:0]       late_o,
  input logic [CNT_W-1:0] cnt_inner_o,
  input logic [CNT_W-1:0] cnt_outer_o
);
  AST_LATE_SRC_INNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    late_o[0] |-> $past(req_valid_i && req_demand_i && !req_lvl_i && res_o == 2'd2)); // R8
  AST_LATE_SRC_OUTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    late_o[1] |-> $past(req_valid_i && req_demand_i && req_lvl_i && res_o == 2'd2)); // R8
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_valid_i && cpl_valid_i == 2'b00) |=> ($stable(cnt_inner_o) && $stable(cnt_outer_o))); // R10
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(cnt_inner_o) <= DEPTH) && (32'(cnt_outer_o) <= DEPTH)); // R10
  AST_ALLOC_GROWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_done_o && !req_lvl_i && cpl_valid_i == 2'b00)
      |=> cnt_inner_o == $past(cnt_inner_o) + CNT_W'(1)); // R4
  AST_ALLOC_RES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_done_o |-> (res_o == 2'd0 || res_o == 2'd3)); // R6
  AST_CPL_INNER_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_valid_i && cpl_valid_i == 2'b01)
      |=> (cnt_outer_o == $past(cnt_outer_o) && cnt_inner_o <= $past(cnt_inner_o))); // R9
endmodule

bind miss_track_table miss_track_table_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_lvl_i   (req_lvl_i),
  .req_demand_i(req_demand_i),
  .res_o       (res_o),
  .alloc_done_o(alloc_done_o),
  .cpl_valid_i (cpl_valid_i),
  .late_o      (late_o),
  .cnt_inner_o (cnt_inner_o),
  .cnt_outer_o (cnt_outer_o)
);

// File: tb/test_miss_track_table.sv
`timescale 1ns/1ps
module test_miss_track_table;
  localparam int DEPTH = 4;
  localparam int AW    = 32;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0, rst_ni = 1'b0;
  logic          req_valid = 0, req_lvl = 0, req_demand = 0, req_alloc = 0;
  logic [AW-1:0] req_addr = '0, cpl_addr0 = '0, cpl_addr1 = '0;
  logic [1:0]    cpl_valid = '0, res, late;
  logic          alloc_done;
  logic [CW-1:0] cnt_in, cnt_out;

  int n_chk = 0, n_fail = 0;
  int r_res, r_ok;
  bit done = 0;

  always #2.5 clk = ~clk;

  miss_track_table #(.DEPTH(DEPTH), .ADDR_W(AW)) i_miss_track_table (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_lvl_i(req_lvl), .req_demand_i(req_demand),
    .req_alloc_i(req_alloc), .req_addr_i(req_addr),
    .res_o(res), .alloc_done_o(alloc_done),
    .cpl_valid_i(cpl_valid), .cpl_addr0_i(cpl_addr0), .cpl_addr1_i(cpl_addr1),
    .late_o(late), .cnt_inner_o(cnt_in), .cnt_outer_o(cnt_out)
  );

  task automatic chk(input int got, input int exp, input string tag);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // request (optionally with completions); called and returns at a falling edge
  task automatic op(input logic lvl, input logic dem, input logic alc, input logic [AW-1:0] a,
                    input logic [1:0] cv = 2'b00, input logic [AW-1:0] ca = '0);
    req_valid = 1; req_lvl = lvl; req_demand = dem; req_alloc = alc; req_addr = a;
    cpl_valid = cv; cpl_addr0 = ca; cpl_addr1 = ca;
    #1;
    r_res = int'(res);
    r_ok  = int'(alloc_done);
    @(negedge clk);
    req_valid = 0; req_alloc = 0; req_demand = 0; cpl_valid = '0;
  endtask

  task automatic cpl(input int lvl, input logic [AW-1:0] ca);
    cpl_valid = (lvl == 0) ? 2'b01 : 2'b10; cpl_addr0 = ca; cpl_addr1 = ca;
    @(negedge clk);
    cpl_valid = '0;
  endtask

  task automatic look(input logic lvl, input logic [AW-1:0] a, input int exp, input string tag);
    op(lvl, 1'b0, 1'b0, a);
    chk(r_res, exp, tag);
  endtask

  task automatic cnts(input int ei, input int eo, input string tag);
    chk(int'(cnt_in), ei, {tag, " inner count"});
    chk(int'(cnt_out), eo, {tag, " outer count"});
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
    finish_run();
  end

  initial begin
    logic [AW-1:0] ln [DEPTH];
    logic [AW-1:0] extra;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    cnts(0, 0, "R1");
    chk(int'(late), 0, "R1 late");
    look(0, 32'h0000_1000, 0, "R1 lookup inner");
    look(1, 32'h0000_1000, 0, "R1 lookup outer");

    // sweep: each level x each request type on an empty table (R3 R4 R9 R2)
    for (int l = 0; l < 2; l++) begin
      for (int d = 0; d < 2; d++) begin
        logic [AW-1:0] base;
        base = 32'h4000 + 32'((l * 2 + d) * 64);
        op(l[0], d[0], 1'b1, base + 32'(l * 2 + d + 1));
        chk(r_res, 0, "R4 insert sees absent");
        chk(r_ok, 1, "R4 insert done");
        cnts(l == 0 ? 1 : 0, l == 1 ? 1 : 0, "R4");
        look(l[0], base, d ? 1 : 2, "R3 own level code (R2 offset)");
        look(!l[0], base + 32'd63, 3, "R3 other level code");
        cpl(l, base + 32'd17);
        cnts(0, 0, "R9 freed");
        look(l[0], base, 0, "R9 absent after completion");
      end
    end

    // fill the table with prefetch lines at level 0
    for (int i = 0; i < DEPTH; i++) begin
      ln[i] = 32'h8000 + 32'(i * 64);
      op(1'b0, 1'b0, 1'b1, ln[i] + 32'(i + 1));
      chk(r_ok, 1, "R4 fill");
      cnts(i + 1, 0, "R10 fill");
    end
    extra = 32'h9000;
    op(1'b0, 1'b1, 1'b1, extra);
    chk(r_res, 0, "R5 full lookup");
    chk(r_ok, 0, "R5 full refused");
    cnts(DEPTH, 0, "R5");

    // R7 non-demand keeps flag; demand returns then clears; R8 pulse
    look(0, ln[0] + 32'd5, 2, "R7 nondemand first");
    look(0, ln[0], 2, "R7 nondemand keeps flag");
    op(1'b0, 1'b1, 1'b0, ln[0]);
    chk(r_res, 2, "R7 demand returns flag");
    chk(int'(late), 1, "R8 inner pulse");
    @(negedge clk);
    chk(int'(late), 0, "R8 pulse single cycle");
    look(0, ln[0], 1, "R7 flag cleared");

    // R6 merge
    look(1, ln[1], 3, "R6 before merge");
    op(1'b1, 1'b0, 1'b1, ln[1]);
    chk(r_res, 3, "R6 merge lookup");
    chk(r_ok, 1, "R6 merge done");
    cnts(DEPTH, 1, "R6 both-level counts");
    look(1, ln[1], 2, "R6 new level prefetch flag");
    look(0, ln[1], 2, "R6 old level kept");
    op(1'b1, 1'b1, 1'b0, ln[1]);
    chk(r_res, 2, "R7 outer demand");
    chk(int'(late), 2, "R8 outer pulse");

    // R9 narrowing and ignored completion
    cpl(0, ln[1]);
    cnts(DEPTH - 1, 1, "R9 revert");
    look(0, ln[1], 3, "R9 reverted to outer");
    look(1, ln[1], 1, "R9 outer still pending");
    cpl(1, ln[1]);
    cnts(DEPTH - 1, 0, "R9 both done");
    look(1, ln[1], 0, "R9 slot freed");
    cpl(1, ln[2]);
    cnts(DEPTH - 1, 0, "R9 wrong-level completion ignored");
    look(0, ln[2], 2, "R9 entry untouched");

    // refill last slot, then allocation racing a completion (R11)
    op(1'b1, 1'b1, 1'b1, ln[1]);
    chk(r_ok, 1, "R4 reuse freed slot");
    cnts(DEPTH - 1, 1, "R10 after reuse");
    op(1'b0, 1'b1, 1'b1, extra, 2'b01, ln[0]);
    chk(r_res, 0, "R11 racing alloc lookup");
    chk(r_ok, 0, "R11 slot freed same cycle not used");
    cnts(DEPTH - 2, 1, "R11 completion applied");
    op(1'b0, 1'b1, 1'b1, extra);
    chk(r_ok, 1, "R11 slot usable next cycle");
    cnts(DEPTH - 1, 1, "R11 after alloc");

    // R11 lookup racing its own completion
    op(1'b0, 1'b1, 1'b0, ln[2], 2'b01, ln[2]);
    chk(r_res, 2, "R11 line still present");
    chk(int'(late), 1, "R11 late pulse");
    cnts(DEPTH - 2, 1, "R11 completion counted");
    look(0, ln[2], 0, "R11 gone after edge");

    finish_run();
  end
endmodule